// File: doc/BRIEF.md
# ADC Register Front End

This block is the bus-facing register set of an 8-bit analog-to-digital converter. A CPU on a simple synchronous bus reaches two byte-wide registers through it. The control/status register at 0x38 holds the channel select, a continuous-mode bit, an interrupt enable and a read-only completion flag. The result register at 0x39 holds the most recent conversion result. The converter core itself lies outside the block. The block drives a one-cycle start pulse and a channel number toward the core, and the core answers with a done strobe that carries an 8-bit result.

Completion is signalled in one of two ways, picked by the interrupt enable. With the enable low, the completion flag rises and software polls it. With the enable high, the flag stays at zero and an interrupt request is raised instead. Reading the result register acknowledges a completion. A write to the control register also drops a pending interrupt and restarts the converter on the channel just written. In continuous mode each result triggers the next start without help from software.

Top module: `adc_fe_top`

## Requirements
- R1: After reset, address 0x38 reads 0x1F (flag, enable and continuous bit 0, channel 11111), address 0x39 reads 0x00, and `irq` and `conv_start` are low.
- R2: A write to 0x38 stores bit 6 (interrupt enable), bit 5 (continuous) and bits 4:0 (channel). Bit 7 of the write data has no effect on the flag.
- R3: A write to 0x38 drives `conv_start` high for exactly the one cycle that follows the write edge. In that cycle `conv_chan` carries the new channel.
- R4: With interrupt enable 0, a done strobe sets the flag. Bit 7 of 0x38 reads 1 from the next cycle on and stays 1 until a read of 0x39 clears it.
- R5: With interrupt enable 1, a done strobe leaves bit 7 of 0x38 reading 0 and drives `irq` high from the next cycle. With enable 0, a done strobe leaves `irq` low.
- R6: `irq` falls in the cycle after a read of 0x39 or a write of 0x38.
- R7: Address 0x39 returns the result carried by the most recent done strobe, updated at that strobe's edge.
- R8: With the continuous bit 1, `conv_start` is high in the cycle after each done strobe. With it 0, a done strobe produces no start.
- R9: When a done strobe and a read of 0x39 fall in the same cycle, the read returns the previous result, and the flag or interrupt of the new result is still raised.
- R10: Any other address reads 0x00. Writes to any address other than 0x38 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register address |
| bus_rd | input | 1 | Read strobe; a read of 0x39 is the acknowledge |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current address (combinational) |
| conv_done | input | 1 | One-cycle end-of-conversion strobe from the core |
| conv_result | input | 8 | Result valid with `conv_done` |
| conv_start | output | 1 | One-cycle start request to the core |
| conv_chan | output | 5 | Channel to convert |
| irq | output | 1 | Interrupt request, level |

## Verification
The bench goes after the dual meaning of bit 7. A design that ignored the enable would show a set flag while interrupts are on, or would raise `irq` while polling. It writes a 1 into bit 7 to catch a flag that can be written. It checks that both acknowledge paths drop `irq`; a design missing one of them leaves the request stuck. It drives a done strobe in the same cycle as a result read. A design that let the clear win would lose that completion, and one that forwarded the new result would return the wrong byte. Continuous mode is checked for its automatic restart, and single mode for the absence of one.

// File: rtl/adc_fe_pkg.sv
package adc_fe_pkg;

    localparam int unsigned AW  = 8;
    localparam int unsigned DW  = 8;
    localparam int unsigned CHW = 5;

    localparam logic [AW-1:0] CTRL_ADDR = 8'h38;
    localparam logic [AW-1:0] DATA_ADDR = 8'h39;

    // bit positions of the control/status byte (software decodes these)
    localparam int unsigned FLAG_BIT = DW - 1;
    localparam int unsigned IEN_BIT  = DW - 2;
    localparam int unsigned CONT_BIT = DW - 3;

    typedef struct packed {
        logic           ien;
        logic           cont;
        logic [CHW-1:0] chan;
    } ctrl_t;

    localparam ctrl_t CTRL_RST = '{ien: 1'b0, cont: 1'b0, chan: '1};

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_CTRL = 2'd1,
        SEL_DATA = 2'd2
    } sel_e;

    function automatic ctrl_t unpack_ctrl(input logic [DW-1:0] w);
        ctrl_t c;
        c.ien  = w[IEN_BIT];
        c.cont = w[CONT_BIT];
        c.chan = w[CHW-1:0];
        return c;
    endfunction

    // the flag is hidden whenever interrupts are enabled
    function automatic logic [DW-1:0] pack_status(input logic flag, input ctrl_t c);
        logic [DW-1:0] b;
        b            = '0;
        b[FLAG_BIT]  = flag & ~c.ien;
        b[IEN_BIT]   = c.ien;
        b[CONT_BIT]  = c.cont;
        b[CHW-1:0]   = c.chan;
        return b;
    endfunction

endpackage

// File: rtl/adc_fe_decode.sv
module adc_fe_decode
    import adc_fe_pkg::*;
(
    input  logic [AW-1:0] addr,
    input  logic          rd,
    input  logic          wr,
    output sel_e          sel,
    output logic          ctrl_wr,
    output logic          data_rd
);

    always_comb begin
        unique case (addr)
            CTRL_ADDR: sel = SEL_CTRL;
            DATA_ADDR: sel = SEL_DATA;
            default:   sel = SEL_NONE;
        endcase
    end

    assign ctrl_wr = wr && (sel == SEL_CTRL);
    assign data_rd = rd && (sel == SEL_DATA);

endmodule

// File: rtl/adc_fe_ctrl.sv
module adc_fe_ctrl
    import adc_fe_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          ctrl_wr,
    input  logic [DW-1:0] wdata,
    input  logic          conv_done,
    output ctrl_t         ctrl,
    output logic          conv_start
);

    logic restart;
    assign restart = ctrl_wr || (conv_done && ctrl.cont);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl       <= CTRL_RST;
            conv_start <= 1'b0;
        end else begin
            if (ctrl_wr) ctrl <= unpack_ctrl(wdata);
            conv_start <= restart;
        end
    end

    p_start_after_write_r3: assert property (@(posedge clk) disable iff (rst)
        ctrl_wr |=> conv_start);

    p_cont_restart_r8: assert property (@(posedge clk) disable iff (rst)
        (conv_done && ctrl.cont) |=> conv_start);

    p_no_spurious_start_r8: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_wr && !(conv_done && ctrl.cont)) |=> !conv_start);

    p_ctrl_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !ctrl_wr |=> $stable(ctrl));

endmodule

// File: rtl/adc_fe_status.sv
module adc_fe_status
    import adc_fe_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          conv_done,
    input  logic [DW-1:0] conv_result,
    input  logic          ien,
    input  logic          ctrl_wr,
    input  logic          data_rd,
    output logic          flag,
    output logic          irq,
    output logic [DW-1:0] data
);

    logic flag_set, irq_set, irq_clr;
    assign flag_set = conv_done && !ien;
    assign irq_set  = conv_done && ien;
    assign irq_clr  = data_rd || ctrl_wr;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
            irq  <= 1'b0;
            data <= '0;
        end else begin
            if (conv_done) data <= conv_result;
            // a set outranks a clear in the same cycle
            if (flag_set)      flag <= 1'b1;
            else if (data_rd)  flag <= 1'b0;
            if (irq_set)       irq  <= 1'b1;
            else if (irq_clr)  irq  <= 1'b0;
        end
    end

    p_flag_set_r4: assert property (@(posedge clk) disable iff (rst)
        (conv_done && !ien) |=> flag);

    p_flag_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (flag && !data_rd) |=> flag);

    p_irq_set_r5: assert property (@(posedge clk) disable iff (rst)
        (conv_done && ien) |=> irq);

    p_irq_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        (!irq && !(conv_done && ien)) |=> !irq);

    p_irq_clear_r6: assert property (@(posedge clk) disable iff (rst)
        ((data_rd || ctrl_wr) && !conv_done) |=> !irq);

    p_result_latch_r7: assert property (@(posedge clk) disable iff (rst)
        conv_done |=> (data == $past(conv_result)));

endmodule

// File: rtl/adc_fe_top.sv
module adc_fe_top
    import adc_fe_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic [AW-1:0]  bus_addr,
    input  logic           bus_rd,
    input  logic           bus_wr,
    input  logic [DW-1:0]  bus_wdata,
    output logic [DW-1:0]  bus_rdata,
    input  logic           conv_done,
    input  logic [DW-1:0]  conv_result,
    output logic           conv_start,
    output logic [CHW-1:0] conv_chan,
    output logic           irq
);

    sel_e          sel;
    logic          ctrl_wr, data_rd;
    ctrl_t         ctrl;
    logic          flag;
    logic [DW-1:0] data;

    adc_fe_decode u_dec (
        .addr    (bus_addr),
        .rd      (bus_rd),
        .wr      (bus_wr),
        .sel     (sel),
        .ctrl_wr (ctrl_wr),
        .data_rd (data_rd)
    );

    adc_fe_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .ctrl_wr    (ctrl_wr),
        .wdata      (bus_wdata),
        .conv_done  (conv_done),
        .ctrl       (ctrl),
        .conv_start (conv_start)
    );

    adc_fe_status u_stat (
        .clk         (clk),
        .rst         (rst),
        .conv_done   (conv_done),
        .conv_result (conv_result),
        .ien         (ctrl.ien),
        .ctrl_wr     (ctrl_wr),
        .data_rd     (data_rd),
        .flag        (flag),
        .irq         (irq),
        .data        (data)
    );

    assign conv_chan = ctrl.chan;

    always_comb begin
        unique case (sel)
            SEL_CTRL: bus_rdata = pack_status(flag, ctrl);
            SEL_DATA: bus_rdata = data;
            default:  bus_rdata = '0;
        endcase
    end

    p_flag_hidden_r5: assert property (@(posedge clk) disable iff (rst)
        (ctrl.ien && sel == SEL_CTRL) |-> !bus_rdata[FLAG_BIT]);

endmodule

// File: tb/adc_fe_top_test.sv
module adc_fe_top_test;
    timeunit 1ns;
    timeprecision 100ps;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] bus_addr = '0;
    logic       bus_rd = 1'b0, bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       conv_done = 1'b0;
    logic [7:0] conv_result = '0;
    logic       conv_start;
    logic [4:0] conv_chan;
    logic       irq;

    always #2.5 clk = ~clk;

    adc_fe_top uut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .conv_done(conv_done), .conv_result(conv_result),
        .conv_start(conv_start), .conv_chan(conv_chan), .irq(irq)
    );

    typedef enum int {OBS_RDATA, OBS_IRQ, OBS_START, OBS_CHAN} obs_e;
    typedef struct {
        string      req;
        obs_e       what;
        logic [7:0] exp;
    } item_t;

    item_t q[$];
    int    n_checks = 0;
    int    n_fail   = 0;
    bit    finished = 0;
    event  sample_ev;

    // monitor: pops every queued expectation and compares with the ports
    initial forever begin
        @(sample_ev);
        while (q.size() > 0) begin
            item_t it;
            logic [7:0] got;
            it = q.pop_front();
            case (it.what)
                OBS_RDATA: got = bus_rdata;
                OBS_IRQ:   got = {7'd0, irq};
                OBS_START: got = {7'd0, conv_start};
                default:   got = {3'd0, conv_chan};
            endcase
            n_checks++;
            if (got !== it.exp) begin
                n_fail++;
                $display("FAIL %s %s: got 0x%02h expected 0x%02h",
                         it.req, it.what.name(), got, it.exp);
            end
        end
    end

    task automatic expect_obs(input string req, input obs_e what, input logic [7:0] exp);
        item_t it;
        it.req = req; it.what = what; it.exp = exp;
        q.push_back(it);
    endtask

    task automatic flush();
        ->sample_ev;
        #0.5;
    endtask

    // advance one clock; inputs change only at the falling edge
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle_bus();
        bus_rd = 1'b0; bus_wr = 1'b0; conv_done = 1'b0;
    endtask

    task automatic peek(input string req, input logic [7:0] a, input logic [7:0] exp);
        bus_addr = a;
        #0.1;
        expect_obs(req, OBS_RDATA, exp);
        flush();
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        step();
        idle_bus();
    endtask

    task automatic done_pulse(input logic [7:0] r);
        conv_result = r; conv_done = 1'b1;
        step();
        idle_bus();
    endtask

    task automatic rd_data(input string req, input logic [7:0] exp);
        bus_addr = 8'h39; bus_rd = 1'b1;
        #0.1;
        expect_obs(req, OBS_RDATA, exp);
        flush();
        step();
        idle_bus();
    endtask

    initial begin
        #100000;
        if (!finished) begin
            finished = 1;
            n_checks++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        step(); step();
        rst = 1'b0;

        // R1 reset state
        expect_obs("R1", OBS_IRQ, 8'h00);
        expect_obs("R1", OBS_START, 8'h00);
        flush();
        peek("R1", 8'h38, 8'h1F);
        peek("R1", 8'h39, 8'h00);

        // R2/R3 write with bit 7 set: flag must not follow
        wr_reg(8'h38, 8'h83);
        expect_obs("R3", OBS_START, 8'h01);
        expect_obs("R3", OBS_CHAN, 8'h03);
        flush();
        peek("R2", 8'h38, 8'h03);
        step();
        expect_obs("R3", OBS_START, 8'h00);
        flush();

        // R4/R5/R8 polled single conversion
        done_pulse(8'hA5);
        expect_obs("R5", OBS_IRQ, 8'h00);
        expect_obs("R8", OBS_START, 8'h00);
        flush();
        peek("R4", 8'h38, 8'h83);
        step();
        peek("R4", 8'h38, 8'h83);
        rd_data("R7", 8'hA5);
        peek("R4", 8'h38, 8'h03);

        // R5/R6 interrupt mode, acknowledged by a result read
        wr_reg(8'h38, 8'h45);
        expect_obs("R3", OBS_START, 8'h01);
        expect_obs("R3", OBS_CHAN, 8'h05);
        flush();
        done_pulse(8'h3C);
        expect_obs("R5", OBS_IRQ, 8'h01);
        flush();
        peek("R5", 8'h38, 8'h45);
        rd_data("R7", 8'h3C);
        expect_obs("R6", OBS_IRQ, 8'h00);
        flush();

        // R6 acknowledged by a control write
        done_pulse(8'h11);
        expect_obs("R5", OBS_IRQ, 8'h01);
        flush();
        wr_reg(8'h38, 8'h46);
        expect_obs("R6", OBS_IRQ, 8'h00);
        expect_obs("R3", OBS_START, 8'h01);
        flush();

        // R8 continuous mode, polled
        wr_reg(8'h38, 8'h26);
        step();
        done_pulse(8'h77);
        expect_obs("R8", OBS_START, 8'h01);
        flush();
        peek("R4", 8'h38, 8'hA6);
        step();
        expect_obs("R8", OBS_START, 8'h00);
        flush();
        rd_data("R7", 8'h77);
        peek("R4", 8'h38, 8'h26);

        // R9 done and result read in the same cycle, flag path
        bus_addr = 8'h39; bus_rd = 1'b1; conv_result = 8'h99; conv_done = 1'b1;
        #0.1;
        expect_obs("R9", OBS_RDATA, 8'h77);
        flush();
        step();
        idle_bus();
        peek("R9", 8'h38, 8'hA6);
        peek("R7", 8'h39, 8'h99);

        // R9 same collision, interrupt path
        wr_reg(8'h38, 8'h40);
        bus_addr = 8'h39; bus_rd = 1'b1; conv_result = 8'h5A; conv_done = 1'b1;
        step();
        idle_bus();
        expect_obs("R9", OBS_IRQ, 8'h01);
        flush();
        rd_data("R7", 8'h5A);

        // R10 other addresses
        wr_reg(8'h39, 8'hFF);
        wr_reg(8'h50, 8'hFF);
        peek("R10", 8'h39, 8'h5A);
        peek("R10", 8'h38, 8'h40);
        peek("R10", 8'h50, 8'h00);
        expect_obs("R10", OBS_START, 8'h00);
        flush();

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule